// File: doc/BRIEF.md
# Serial Converter Capture Host

This block is the host side of a link to a serial sampling converter. On a start request, or on a fixed cadence while automatic mode is enabled, it raises the convert line for one half period. It then runs a burst of eighteen serial clock cycles and samples the converter's data line on each falling clock edge. The data bits are assembled into a result word. The converter returns the result of the conversion started one frame earlier. The word is therefore published on an output named for the previous conversion, and a word that has no earlier conversion behind it is withheld.

The same pins also carry power commands. A short train of convert pulses with the serial clock parked low asks the converter to nap, and a longer train asks it to sleep. A wake command issues serial clock pulses while the convert line stays low. The serial clock half period, the pulse counts, the frame length and the automatic cadence are all parameters. A narrow mode captures twelve result bits instead of fourteen and discards the padding bits that follow.

Top module: `adc_cap_host`

## Requirements
- R1: After reset, and whenever busy is low, conv and sck are low; prevValid is low after reset.
- R2: An accepted start produces exactly one conv pulse, followed by exactly 18 sck pulses, with conv and sck never high together; busy stays high for 38 sck half periods (38*CLK_DIV clock cycles).
- R3: In wide mode (narrowMode=0) the data line is sampled when sck falls, serial clock cycles 1 and 2 are skipped, and cycles 3 to 16 are shifted in most significant bit first to form prevWord[13:0].
- R4: In narrow mode (narrowMode=1) only cycles 3 to 14 are captured into prevWord[11:0], the trailing padding bits are dropped, and prevWord[13:12] read 0 because the shift register is cleared at frame start.
- R5: prevValid pulses for one cycle at the end of a frame, with busy already low, and carries the bits received during that frame (the previous conversion's result).
- R6: The first frame after reset produces no prevValid pulse.
- R7: startReq, napReq, sleepReq and wakeReq that arrive while busy is high are ignored and do not change the running frame.
- R8: A nap command produces exactly 2 conv pulses, no sck pulse and no prevValid.
- R9: A sleep command produces exactly 4 conv pulses and no sck pulse.
- R10: A wake command produces exactly 1 sck pulse and no conv pulse, and the first frame after it produces no prevValid.
- R11: While autoEn is high, one frame starts every RATE_CYCLES clock cycles, counted from the cycle autoEn is raised.
- R12: Requests that arrive together in an idle cycle are served in the order wake, sleep, nap, start; only the winner is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start one capture frame |
| autoEn | input | 1 | Enable periodic frames |
| napReq | input | 1 | Send the nap pulse train |
| sleepReq | input | 1 | Send the sleep pulse train |
| wakeReq | input | 1 | Send wake clock pulses |
| narrowMode | input | 1 | 1 = 12-bit capture, 0 = 14-bit capture |
| sdi | input | 1 | Serial data from the converter |
| conv | output | 1 | Convert start to the converter |
| sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame or command in progress |
| prevValid | output | 1 | One-cycle strobe for prevWord |
| prevWord | output | DATA_BITS | Result of the previous conversion |

## Verification
The hardest behaviour to reach is the link between a word and its conversion. It depends on the converter's memory, which the host never sees. The bench therefore contains a behavioural converter. That model latches a new sample on each convert rising edge and streams the older sample on the following sck rising edges, with the skipped and padding positions driven high. A sweep of frames with changing sample values then shows that each published word equals the sample given one frame earlier. Requests that land while a frame is running are injected from inside the bench's busy-wait loop, part way through the frame.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FRAME = 3'd1,
    ST_NAP   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic shiftEn;
    logic emit;
  } dpStrobe_t;

endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int CLK_DIV      = 2,
  parameter int FRAME_SCKS   = 18,
  parameter int SKIP_SCKS    = 2,
  parameter int DATA_BITS    = 14,
  parameter int NARROW_DROP  = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  parameter int WAKE_PULSES  = 1,
  parameter int RATE_CYCLES  = 100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startReq,
  input  logic      autoEn,
  input  logic      napReq,
  input  logic      sleepReq,
  input  logic      wakeReq,
  input  logic      narrowMode,
  output logic      conv,
  output logic      sck,
  output logic      busy,
  output dpStrobe_t strb
);

  localparam int FRAME_HALVES = 2 + 2 * FRAME_SCKS;
  localparam int PWR_MAX      = (SLEEP_PULSES > NAP_PULSES) ? SLEEP_PULSES : NAP_PULSES;
  localparam int CMD_MAX      = (PWR_MAX > WAKE_PULSES) ? PWR_MAX : WAKE_PULSES;
  localparam int MAX_HALVES   = (FRAME_HALVES > 2 * CMD_MAX) ? FRAME_HALVES : 2 * CMD_MAX;
  localparam int HW           = $clog2(MAX_HALVES + 1);
  localparam int RW           = (RATE_CYCLES > 1) ? $clog2(RATE_CYCLES) : 1;

  localparam logic [HW-1:0] FRAME_LAST = HW'(FRAME_HALVES - 1);
  localparam logic [HW-1:0] NAP_LAST   = HW'(2 * NAP_PULSES - 1);
  localparam logic [HW-1:0] SLEEP_LAST = HW'(2 * SLEEP_PULSES - 1);
  localparam logic [HW-1:0] WAKE_LAST  = HW'(2 * WAKE_PULSES - 1);
  localparam logic [HW-1:0] FIRST_SCK  = HW'(2);
  localparam logic [HW-1:0] CAP_LO     = HW'(SKIP_SCKS);
  localparam logic [HW-1:0] CAP_HI_W   = HW'(SKIP_SCKS + DATA_BITS - 1);
  localparam logic [HW-1:0] CAP_HI_N   = HW'(SKIP_SCKS + DATA_BITS - NARROW_DROP - 1);
  localparam logic [RW-1:0] RATE_LAST  = RW'(RATE_CYCLES - 1);

  capState_t     state;
  logic [HW-1:0] halfIdx;
  logic [HW-1:0] lastHalf;
  logic [HW-1:0] sckIdx;
  logic [HW-1:0] capHi;
  logic [RW-1:0] rateCnt;
  logic          tick;
  logic          stale;
  logic          rateHit;
  logic          goFrame;
  logic          endCmd;

  // half-period timer: one tick per CLK_DIV clocks while active
  generate
    if (CLK_DIV == 1) begin : g_div_bypass
      assign tick = 1'b1;
    end else begin : g_div_count
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) divCnt <= '0;
        else if (divCnt == DIV_LAST)    divCnt <= '0;
        else                            divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_LAST);
    end
  endgenerate

  // periodic trigger
  always_ff @(posedge clk) begin
    if (!rst_n || !autoEn)      rateCnt <= '0;
    else if (rateCnt == RATE_LAST) rateCnt <= '0;
    else                        rateCnt <= rateCnt + 1'b1;
  end
  assign rateHit = autoEn && (rateCnt == RATE_LAST);

  always_comb begin
    case (state)
      ST_FRAME: lastHalf = FRAME_LAST;
      ST_NAP:   lastHalf = NAP_LAST;
      ST_SLEEP: lastHalf = SLEEP_LAST;
      ST_WAKE:  lastHalf = WAKE_LAST;
      default:  lastHalf = '0;
    endcase
  end

  assign endCmd  = (state != ST_IDLE) && tick && (halfIdx == lastHalf);
  assign goFrame = (state == ST_IDLE) && !wakeReq && !sleepReq && !napReq
                   && (startReq || rateHit);

  // pin levels decoded from the registered half-period position
  assign sckIdx = (halfIdx - FIRST_SCK) >> 1;
  assign capHi  = narrowMode ? CAP_HI_N : CAP_HI_W;
  assign conv   = ((state == ST_FRAME) && (halfIdx == '0))
               || (((state == ST_NAP) || (state == ST_SLEEP)) && !halfIdx[0]);
  assign sck    = ((state == ST_FRAME) && (halfIdx >= FIRST_SCK) && !halfIdx[0])
               || ((state == ST_WAKE) && !halfIdx[0]);
  assign busy   = (state != ST_IDLE);

  assign strb.clearShift = goFrame;
  assign strb.shiftEn    = (state == ST_FRAME) && tick && (halfIdx >= FIRST_SCK)
                           && !halfIdx[0] && (sckIdx >= CAP_LO) && (sckIdx <= capHi);
  assign strb.emit       = (state == ST_FRAME) && endCmd && !stale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      halfIdx <= '0;
      stale   <= 1'b1;
    end else if (state == ST_IDLE) begin
      halfIdx <= '0;
      if (wakeReq) begin
        state <= ST_WAKE;
        stale <= 1'b1;
      end else if (sleepReq) begin
        state <= ST_SLEEP;
      end else if (napReq) begin
        state <= ST_NAP;
      end else if (goFrame) begin
        state <= ST_FRAME;
      end
    end else if (endCmd) begin
      if (state == ST_FRAME) stale <= 1'b0;
      state   <= ST_IDLE;
      halfIdx <= '0;
    end else if (tick) begin
      halfIdx <= halfIdx + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!conv && !sck));
  p_pins_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv && sck));
  p_shift_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftEn |-> sck);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !endCmd) |=> busy);
  p_nap_sck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NAP) |-> !sck);
  p_sleep_sck_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> !sck);
  p_wake_conv_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> !conv);

endmodule

// File: rtl/adc_cap_dp.sv
module adc_cap_dp
  import adc_cap_pkg::*;
#(
  parameter int DATA_BITS = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            strb,
  input  logic                 sdi,
  output logic                 prevValid,
  output logic [DATA_BITS-1:0] prevWord
);

  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clearShift) shiftReg <= '0;
    else if (strb.shiftEn)         shiftReg <= {shiftReg[DATA_BITS-2:0], sdi};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevValid <= 1'b0;
      prevWord  <= '0;
    end else begin
      prevValid <= strb.emit;
      if (strb.emit) prevWord <= shiftReg;
    end
  end

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prevValid |=> !prevValid);

endmodule

// File: rtl/adc_cap_host.sv
module adc_cap_host
  import adc_cap_pkg::*;
#(
  parameter int CLK_DIV      = 2,
  parameter int FRAME_SCKS   = 18,
  parameter int SKIP_SCKS    = 2,
  parameter int DATA_BITS    = 14,
  parameter int NARROW_DROP  = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  parameter int WAKE_PULSES  = 1,
  parameter int RATE_CYCLES  = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 startReq,
  input  logic                 autoEn,
  input  logic                 napReq,
  input  logic                 sleepReq,
  input  logic                 wakeReq,
  input  logic                 narrowMode,
  input  logic                 sdi,
  output logic                 conv,
  output logic                 sck,
  output logic                 busy,
  output logic                 prevValid,
  output logic [DATA_BITS-1:0] prevWord
);

  dpStrobe_t strb;

  adc_cap_ctrl #(
    .CLK_DIV(CLK_DIV), .FRAME_SCKS(FRAME_SCKS), .SKIP_SCKS(SKIP_SCKS),
    .DATA_BITS(DATA_BITS), .NARROW_DROP(NARROW_DROP), .NAP_PULSES(NAP_PULSES),
    .SLEEP_PULSES(SLEEP_PULSES), .WAKE_PULSES(WAKE_PULSES), .RATE_CYCLES(RATE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .autoEn(autoEn),
    .napReq(napReq), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .narrowMode(narrowMode), .conv(conv), .sck(sck), .busy(busy), .strb(strb)
  );

  adc_cap_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sdi(sdi),
    .prevValid(prevValid), .prevWord(prevWord)
  );

  p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prevValid |-> !busy);

endmodule

// File: tb/adc_cap_host_test.sv
module adc_cap_host_test;

  localparam int DIV   = 2;
  localparam int RATE  = 100;
  localparam int HALVES = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 0, autoEn = 0, napReq = 0, sleepReq = 0, wakeReq = 0;
  logic narrowMode = 0;
  logic sdi = 1'b1;
  logic conv, sck, busy, prevValid;
  logic [13:0] prevWord;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  adc_cap_host uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .autoEn(autoEn),
    .napReq(napReq), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .narrowMode(narrowMode), .sdi(sdi), .conv(conv), .sck(sck), .busy(busy),
    .prevValid(prevValid), .prevWord(prevWord)
  );

  // behavioural converter: streams the sample latched one conversion earlier
  logic [13:0] nextSample = '0;
  logic [13:0] heldWord = '0;
  logic [13:0] outWord = '0;
  int bitIdx = 0;
  bit modelPwr = 0;

  always @(posedge conv) begin
    if (!modelPwr) begin
      outWord  = heldWord;
      heldWord = nextSample;
      bitIdx   = 0;
    end
  end

  always @(posedge sck) begin
    #1;
    bitIdx++;
    if (bitIdx >= 3 && bitIdx <= (narrowMode ? 14 : 16)) sdi = outWord[16 - bitIdx];
    else sdi = 1'b1;
  end

  // pulse and strobe monitors
  int convRise = 0, sckRise = 0, validCnt = 0;
  logic [13:0] lastWord = '0;
  always @(posedge conv) convRise++;
  always @(posedge sck)  sckRise++;
  always @(negedge clk) if (prevValid) begin validCnt++; lastWord = prevWord; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearCounts();
    convRise = 0; sckRise = 0; validCnt = 0;
  endtask

  logic [13:0] lastSample = '0;

  task automatic runFrame(input logic [13:0] smp, input bit expValid, input bit poke);
    int busyCyc = 0;
    logic [13:0] expWord;
    nextSample = smp;
    clearCounts();
    @(negedge clk) startReq = 1;
    @(negedge clk) startReq = 0;
    while (busy) begin
      busyCyc++;
      if (poke && busyCyc == 20) begin startReq = 1; napReq = 1; sleepReq = 1; wakeReq = 1; end
      else begin startReq = 0; napReq = 0; sleepReq = 0; wakeReq = 0; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(convRise == 1, poke ? "R7 conv" : "R2 conv", convRise, 1);
    chk(sckRise == 18, poke ? "R7 sck" : "R2 sck", sckRise, 18);
    chk(busyCyc == HALVES * DIV, "R2 busy", busyCyc, HALVES * DIV);
    expWord = narrowMode ? (lastSample >> 2) : lastSample;
    if (expValid) begin
      chk(validCnt == 1, "R5 valid", validCnt, 1);
      chk(lastWord == expWord, narrowMode ? "R4 word" : "R3 R5 word", lastWord, expWord);
    end else begin
      chk(validCnt == 0, "R6 R10 suppressed", validCnt, 0);
    end
    lastSample = smp;
  endtask

  // reqs = {wake, sleep, nap, start}
  task automatic runCmd(input logic [3:0] reqs, input int expConv, input int expSck, input string req);
    clearCounts();
    modelPwr = 1;
    @(negedge clk) {wakeReq, sleepReq, napReq, startReq} = reqs;
    @(negedge clk) {wakeReq, sleepReq, napReq, startReq} = 4'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    modelPwr = 0;
    chk(convRise == expConv, req, convRise, expConv);
    chk(sckRise == expSck, req, sckRise, expSck);
    chk(validCnt == 0, req, validCnt, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!conv && !sck && !busy && !prevValid, "R1 reset", {conv, sck, busy, prevValid}, 0);

    // R6: first frame after reset is withheld
    runFrame(14'h3FFF, 0, 0);

    // R3 R5: wide sweep, each word is the sample from the frame before
    for (int i = 0; i < 24; i++) begin
      logic [13:0] v;
      v = (i == 0) ? 14'h0000 : (i == 1) ? 14'h3FFF : (i == 2) ? 14'h2AAA :
          14'((i * 5227 + 3) & 16'h3FFF);
      runFrame(v, 1, 0);
    end

    // R4: narrow mode, previous wide frame left ones in the register
    runFrame(14'h3FFF, 1, 0);
    narrowMode = 1;
    for (int i = 0; i < 10; i++) runFrame(14'((i * 3371 + 11) & 16'h3FFF), 1, 0);
    narrowMode = 0;
    runFrame(14'h1555, 1, 0);

    // R7: requests injected mid-frame are ignored
    runFrame(14'h0F0F, 1, 1);
    runFrame(14'h30C3, 1, 0);

    // R8 nap, R9 sleep, R12 priority
    runCmd(4'b0010, 2, 0, "R8 nap");
    runCmd(4'b0011, 2, 0, "R12 nap over start");
    runCmd(4'b0100, 4, 0, "R9 sleep");
    runCmd(4'b0111, 4, 0, "R12 sleep over nap");

    // frames after power commands keep pairing
    runFrame(14'h0ABC, 1, 0);

    // R10 wake, and R12 wake wins over all
    runCmd(4'b1000, 0, 1, "R10 wake");
    runFrame(14'h1234, 0, 0);
    runFrame(14'h2345, 1, 0);
    runCmd(4'b1111, 0, 1, "R12 wake over all");
    runFrame(14'h0777, 0, 0);

    // R11: periodic frames
    clearCounts();
    nextSample = 14'h1ACE;
    @(negedge clk) autoEn = 1;
    repeat (3 * RATE) @(negedge clk);
    autoEn = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(convRise == 3, "R11 frames", convRise, 3);
    chk(validCnt == 3, "R11 words", validCnt, 3);
    chk(lastWord == 14'h1ACE, "R11 last word", lastWord, 14'h1ACE);
    chk(!conv && !sck && !busy, "R1 idle pins", {conv, sck, busy}, 0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule